// File: doc/BRIEF.md
# Biphase Mark Line Encoder

This block turns a serial bit stream into a biphase mark coded line level using one system clock. An internal bit timer divides each bit period into two halves of equal length. The line changes level at the start of every bit. It changes level again at mid-bit only when the bit being sent is a 1. Because of this the receiver can recover the clock from the line, and the line carries no DC bias over a long run.

Two registers build the code, and the line is their XOR. The first register toggles at mid-bit, and only when the sampled data bit is 1. It keeps its value across bit boundaries. The second register toggles once per bit, at the bit start, so it is the bit rate divided by two. The block gives the data source a one-cycle bit-start strobe. The source places the next bit on its data input during that strobe cycle and holds it through the first half of the bit. Preamble insertion, parity and framing are handled elsewhere.

Top module: `bmc_line_encoder`

## Requirements
- R1: `bit_start` is high for exactly one cycle in every `BIT_CYCLES` cycles. The first pulse comes in the first cycle after `rst_n` is released. `BIT_CYCLES` is even and at least 4 (default 8).
- R2: In every cycle in which `bit_start` is high, `line_out` differs from its value in the previous cycle. This also holds for the first bit after reset, which starts from the idle level 0.
- R3: In the cycle `BIT_CYCLES/2` cycles after `bit_start` (the mid-bit cycle), `line_out` toggles if the data bit is 1 and holds if it is 0. The data bit is the value of `data_in` at the clock edge that ends the cycle just before mid-bit.
- R4: `line_out` changes only in a bit-start cycle or a mid-bit cycle. In every other cycle it keeps its previous value.
- R5: While `rst_n` is low at a clock edge, the next cycle shows `line_out` = 0 and `bit_start` = 0. The reset is synchronous and active low.
- R6: A change of `data_in` after the mid-bit sampling edge, before the next `bit_start`, does not affect `line_out` in the rest of that bit.
- R7: The line level after each bit equals the level before that bit, inverted, then XORed with the data bit. A reset in the middle of a stream restarts this sequence from level 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 1 | Serial data bit; hold from the bit-start cycle through the first half of the bit |
| bit_start | output | 1 | One-cycle strobe that marks the first cycle of each bit period |
| line_out | output | 1 | Biphase mark coded line level |

## Verification
If the mid-bit toggle register is wrong, the line shows a missing or extra mid-bit transition. The error becomes visible in the mid-bit cycle of the affected bit. Every later bit is then sent at the inverted level, although its transitions still occur at the right points. If the divide-by-two register or the bit timer is wrong, the line misses a bit-start transition or `bit_start` drifts from its fixed period, and this shows within one bit period. The bench models the line level bit by bit from the data it drives. It compares the level at both decision points of every bit and checks that the line holds still in every other cycle. In that way a single wrong toggle is caught in the cycle it occurs.

// File: rtl/bmc_enc_pkg.sv
// Package: shared types for the biphase mark line encoder.
// Assumes: nothing; holds types only.
package bmc_enc_pkg;

    // Phase information produced by the bit timer for one cycle.
    typedef struct packed {
        logic in_start;   // current cycle is the first cycle of a bit
        logic in_mid;     // current cycle is the first cycle of the second half
        logic to_start;   // next rising edge enters a new bit
        logic to_mid;     // next rising edge enters the second half
    } bmc_phase_t;

endpackage

// File: rtl/bmc_bit_timer.sv
// Module: bmc_bit_timer
// Counts system clocks within one bit period and reports the current phase
// and the phase that the next edge enters.
// Assumes: BIT_CYCLES is even and >= 4. During reset the counter rests on the
// last cycle of a bit, so the first edge after release starts bit 0.
module bmc_bit_timer
    import bmc_enc_pkg::*;
#(
    parameter int BIT_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    output bmc_phase_t phase
);

    localparam int HALF  = BIT_CYCLES / 2;
    localparam int CNT_W = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BIT_CYCLES - 1);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(HALF);
    localparam logic [CNT_W-1:0] PRE_MID  = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;

    // Purpose: advance the in-bit cycle counter and wrap at the end of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= LAST_CNT;
        end else if (cnt == LAST_CNT) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Purpose: decode the counter into current and upcoming phase flags.
    always_comb begin
        phase.in_start = rst_n && (cnt == '0);
        phase.in_mid   = rst_n && (cnt == MID_CNT);
        phase.to_start = (cnt == LAST_CNT);
        phase.to_mid   = (cnt == PRE_MID);
    end

endmodule

// File: rtl/bmc_mid_toggle.sv
// Module: bmc_mid_toggle
// Mid-bit register. On its enable it takes its own value XOR the data bit,
// so it toggles for a 1 and holds for a 0. It keeps its value across bit
// boundaries.
// Assumes: en is a one-cycle pulse at the mid-bit edge, and data is stable
// while it is sampled.
module bmc_mid_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic data,
    output logic q
);

    // Purpose: fold the data bit into the toggle state at mid-bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (en) begin
            q <= q ^ data;
        end
    end

endmodule

// File: rtl/bmc_bit_divider.sv
// Module: bmc_bit_divider
// Divide-by-two register: inverts once per bit period, so it holds alternate
// levels on alternate bits.
// Assumes: en is a one-cycle pulse at each bit-start edge.
module bmc_bit_divider (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic q
);

    // Purpose: invert on every bit-start enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (en) begin
            q <= ~q;
        end
    end

endmodule

// File: rtl/bmc_line_encoder.sv
// Module: bmc_line_encoder (top)
// Biphase mark encoder. The line is the XOR of a mid-bit toggle register,
// which moves only on data 1, and a per-bit divide-by-two register. The
// result is a transition at every bit start and one more at mid-bit for a 1.
// Assumes: data_in is valid from the bit_start cycle through the cycle
// before mid-bit. Idle level after reset is 0.
module bmc_line_encoder
    import bmc_enc_pkg::*;
#(
    parameter int BIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    output logic bit_start,
    output logic line_out
);

    bmc_phase_t phase;
    logic       q_mid;
    logic       q_div;
    logic       mid_tick;

    bmc_bit_timer #(
        .BIT_CYCLES(BIT_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .phase(phase)
    );

    bmc_mid_toggle u_mid (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (phase.to_mid),
        .data (data_in),
        .q    (q_mid)
    );

    bmc_bit_divider u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (phase.to_start),
        .q    (q_div)
    );

    // Purpose: combine both registers into the line and expose the phase strobes.
    always_comb begin
        line_out  = q_mid ^ q_div;
        bit_start = phase.in_start;
        mid_tick  = phase.in_mid;
    end

endmodule

// File: rtl/bmc_line_encoder_chk.sv
// Module: bmc_line_encoder_chk
// Property checker for bmc_line_encoder, attached to it by the bind below.
// Assumes: mid_tick is the top's internal mid-bit phase flag.
module bmc_line_encoder_chk #(
    parameter int BIT_CYCLES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic data_in,
    input logic bit_start,
    input logic mid_tick,
    input logic line_out
);

    localparam int GAP_W = $clog2(BIT_CYCLES) + 2;

    logic [GAP_W-1:0] gap;
    logic             seen;

    // Purpose: count cycles since the last bit_start to check the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (bit_start) begin
            gap  <= GAP_W'(1);
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1'b1;
        end
    end

    a_r1_period: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_start && seen) |-> (gap == GAP_W'(BIT_CYCLES)));

    a_r1_no_late_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_start && seen) |-> (gap < GAP_W'(BIT_CYCLES)));

    a_r2_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |-> (line_out != $past(line_out)));

    a_r3_mid_edge: assert property (@(posedge clk) disable iff (!rst_n)
        mid_tick |-> ((line_out ^ $past(line_out)) == $past(data_in)));

    a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_start && !mid_tick) |-> $stable(line_out));

    a_r4_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_start, mid_tick}));

    a_r5_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (line_out == 1'b0 && bit_start == 1'b0));

endmodule

bind bmc_line_encoder bmc_line_encoder_chk #(
    .BIT_CYCLES(BIT_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_in  (data_in),
    .bit_start(bit_start),
    .mid_tick (mid_tick),
    .line_out (line_out)
);

// File: tb/bmc_line_encoder_tb.sv
// Scoreboard bench: the driver pushes the expected start and mid levels of
// each bit, and the monitor checks them at the matching cycles.
module bmc_line_encoder_tb;

    localparam int BC   = 8;
    localparam int HALF = BC / 2;

    typedef struct packed {
        logic s_lvl;
        logic m_lvl;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic data_in;
    logic bit_start;
    logic line_out;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    logic exp_lvl;
    logic [7:0] lfsr;

    always #5 clk = ~clk;

    bmc_line_encoder #(
        .BIT_CYCLES(BC)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_in  (data_in),
        .bit_start(bit_start),
        .line_out (line_out)
    );

    task automatic chk(input bit ok, input string req, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: wait for the bit start, present data, push the expected levels (R7).
    task automatic send_bit(input logic d, input bit junk);
        exp_t e;
        do @(negedge clk); while (!bit_start);
        data_in  = d;
        e.s_lvl  = ~exp_lvl;
        e.m_lvl  = e.s_lvl ^ d;
        exp_lvl  = e.m_lvl;
        exp_q.push_back(e);
        if (junk) begin
            // R6: disturb data after the mid-bit sampling edge
            repeat (HALF + 1) @(negedge clk);
            data_in = ~d;
        end
    endtask

    // Monitor: compare line levels and bit timing.
    int   off = -1;
    logic prev_line = 1'b0;
    logic start_seen;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                chk(line_out == 1'b0, "R5 line idle in reset", line_out, 1'b0);
                chk(bit_start == 1'b0, "R5 no strobe in reset", bit_start, 1'b0);
                off = -1;
            end else if (bit_start) begin
                if (off >= 0)
                    chk(off == BC - 1, "R1 bit period", logic'(off == BC - 1), 1'b1);
                chk(line_out != prev_line, "R2 start transition", line_out, ~prev_line);
                start_seen = line_out;
                off = 0;
            end else if (off >= 0) begin
                off++;
                if (off == HALF) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 missing expectation", 1'b0, 1'b1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(start_seen == e.s_lvl, "R7 start level", start_seen, e.s_lvl);
                        chk(line_out == e.m_lvl, "R3 mid level", line_out, e.m_lvl);
                    end
                end else begin
                    chk(line_out == prev_line, "R4/R6 steady line", line_out, prev_line);
                end
                if (off >= BC)
                    chk(1'b0, "R1 strobe missing", 1'b0, 1'b1);
            end
            prev_line = line_out;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        data_in = 1'b0;
        exp_lvl = 1'b0;
        lfsr    = 8'hA5;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2/R4: all zeros, only bit-start transitions
        for (int i = 0; i < 10; i++) send_bit(1'b0, 1'b0);
        // R3: all ones
        for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b0);
        // R3: alternating
        for (int i = 0; i < 16; i++) send_bit(logic'(i % 2), 1'b0);
        // R3/R6: pseudo-random data with disturbed tails
        for (int i = 0; i < 40; i++) begin
            send_bit(lfsr[0], logic'(i % 2));
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        repeat (HALF + 1) @(negedge clk);

        // R5/R7: reset mid-stream and restart from level 0
        rst_n = 1'b0;
        exp_q.delete();
        exp_lvl = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            send_bit(lfsr[1], 1'b1);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        repeat (HALF + 1) @(negedge clk);

        chk(exp_q.size() == 0, "R3 all bits observed",
            logic'(exp_q.size() == 0), 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule